// File: doc/BRIEF.md
# Pin I/O Controller with Level and Edge Interrupts

This block is a register-mapped controller for up to 32 general-purpose pins. Software drives pins through an output data register and an output enable register. It reads the pins through an input register, which samples them through a synchronizer chain. Each pin can raise an interrupt in two ways, each with its own polarity bit and its own enable bit:

- a live level condition;
- a latched edge flag, which software clears by writing ones.

All pending pin sources fold into one summary bit in a top status word. A top enable bit gates that summary onto a single registered interrupt line.

Access goes through a flat register port. A write is taken on a clock edge when `reg_wr` is high. A read is combinational from `reg_addr`. Register bits above the pin count read as zero, and so does any offset that is not mapped.

Top module: `ioc_gpio_irq`

## Requirements
- R1: After reset every register reads zero, and `pin_out`, `pin_oe` and `irq` are all low.
- R2: A write to the drive-value register (offset 0x44) or the drive-enable register (offset 0x48) shows on `pin_out` or `pin_oe`, respectively, in the cycle after the write, and reads back unchanged.
- R3: The sampled-input register (offset 0x40) shows a pin change two clock edges after the change, whatever the drive-enable setting. It still shows the old value after one edge.
- R4: A pin's level source is active when (sampled input XOR level-polarity bit at 0x50) AND level-enable bit at 0x54 is 1. A polarity bit of 1 means active-low.
- R5: The edge-polarity bit (offset 0x64) selects the edge that sets the pin's flag in the edge-flag register (offset 0x58): 0 selects rising and 1 selects falling. The flag sets on the third clock edge after the pin change. The opposite edge leaves the flag unchanged.
- R6: Writing 1 to a bit of the edge-flag register clears it. Writing 0 leaves it unchanged.
- R7: A pin's edge source is its flag AND its edge-enable bit (offset 0x5C). A flag whose enable bit is 0 does not make the pin pending. A pin is pending when its edge source or its level source is active.
- R8: Bit 0 of the top status word (offset 0x00) is 1 whenever any pin is pending. Writes to this word have no effect.
- R9: `irq` is registered. It equals top status bit 0 AND top enable bit 0 (offset 0x04), one clock edge later.
- R10: When a new selected edge and a clearing write to the same flag fall in the same cycle, the flag stays set.
- R11: Reads of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | AW (8) | Byte offset of the register |
| reg_wr | input | 1 | Write strobe, taken on the rising clock edge |
| reg_wdata | input | DW (32) | Write data |
| reg_rdata | output | DW (32) | Combinational read data |
| pin_in | input | NPINS (16) | Asynchronous pin inputs |
| pin_out | output | NPINS (16) | Value driven on each pin |
| pin_oe | output | NPINS (16) | Per-pin drive enable |
| irq | output | 1 | Registered interrupt line |

## Verification
A pin change reaches the sampled-input register and the level state of the status word after two clock edges. It reaches the edge flags after three edges. It reaches `irq` one edge after the status word changes. Register writes show on the pins one edge after the write.

The bench drives all inputs on the falling clock edge and reads half a cycle later. It checks the output both one edge before and exactly on the edge where a result becomes due, so an extra or missing register stage is detected. The collision test places the clearing write precisely in the cycle where the new edge is detected.

// File: rtl/ioc_pkg.sv
package ioc_pkg;
   localparam logic [7:0] OFS_TOP_STAT = 8'h00;
   localparam logic [7:0] OFS_TOP_EN   = 8'h04;
   localparam logic [7:0] OFS_SAMPLE   = 8'h40;
   localparam logic [7:0] OFS_DRV_VAL  = 8'h44;
   localparam logic [7:0] OFS_DRV_EN   = 8'h48;
   localparam logic [7:0] OFS_LVL_POL  = 8'h50;
   localparam logic [7:0] OFS_LVL_EN   = 8'h54;
   localparam logic [7:0] OFS_EDG_FLAG = 8'h58;
   localparam logic [7:0] OFS_EDG_EN   = 8'h5C;
   localparam logic [7:0] OFS_EDG_POL  = 8'h64;

   typedef struct packed {
      logic lvl_pol;
      logic lvl_en;
      logic edg_pol;
      logic edg_en;
   } pin_cfg_t;
endpackage

// File: rtl/ioc_sync.sv
module ioc_sync #(
   parameter int W      = 16,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   localparam int LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("ioc_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][W-1:0] chain;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign q = chain[LAST];
endmodule

// File: rtl/ioc_pin_slice.sv
module ioc_pin_slice
   import ioc_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     smp,
   input  pin_cfg_t cfg,
   input  logic     clr,
   output logic     flag,
   output logic     pend
);
   logic prev;
   logic rise;
   logic fall;
   logic hit;
   logic lvl_act;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b0;
      else        prev <= smp;
   end

   assign rise = smp & ~prev;
   assign fall = ~smp & prev;
   assign hit  = cfg.edg_pol ? fall : rise;

   // a new edge takes precedence over a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   flag <= 1'b0;
      else if (hit) flag <= 1'b1;
      else if (clr) flag <= 1'b0;
   end

   assign lvl_act = (smp ^ cfg.lvl_pol) & cfg.lvl_en;
   assign pend    = lvl_act | (flag & cfg.edg_en);

   // R5
   edge_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> flag);
   // R10
   edge_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && clr) |=> flag);
   // R6
   clear_drops_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !hit) |=> !flag);
   // R6
   flag_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !clr) |=> flag);
endmodule

// File: rtl/ioc_gpio_irq.sv
module ioc_gpio_irq
   import ioc_pkg::*;
#(
   parameter int NPINS       = 16,
   parameter int DW          = 32,
   parameter int AW          = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [AW-1:0]    reg_addr,
   input  logic             reg_wr,
   input  logic [DW-1:0]    reg_wdata,
   output logic [DW-1:0]    reg_rdata,
   input  logic [NPINS-1:0] pin_in,
   output logic [NPINS-1:0] pin_out,
   output logic [NPINS-1:0] pin_oe,
   output logic             irq
);
   localparam int OFS_W = 8;

   if (NPINS < 1 || NPINS > 32) begin : g_bad_npins
      $error("ioc_gpio_irq: NPINS must be in 1..32");
   end
   if (DW < NPINS) begin : g_bad_dw
      $error("ioc_gpio_irq: DW must cover NPINS");
   end
   if (AW < OFS_W) begin : g_bad_aw
      $error("ioc_gpio_irq: AW must be at least 8");
   end

   logic [OFS_W-1:0] ofs;
   logic             hi_zero;
   logic [NPINS-1:0] smp;
   logic [NPINS-1:0] drv_val;
   logic [NPINS-1:0] drv_en;
   logic [NPINS-1:0] lvl_pol;
   logic [NPINS-1:0] lvl_en;
   logic [NPINS-1:0] edg_pol;
   logic [NPINS-1:0] edg_en;
   logic [NPINS-1:0] flag;
   logic [NPINS-1:0] pend;
   logic [NPINS-1:0] clr;
   logic             top_en;
   logic             summary;
   logic             wr_flag;

   assign ofs = reg_addr[OFS_W-1:0];

   if (AW > OFS_W) begin : g_hi
      assign hi_zero = (reg_addr[AW-1:OFS_W] == '0);
   end else begin : g_nohi
      assign hi_zero = 1'b1;
   end

   ioc_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (pin_in),
      .q    (smp)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         drv_val <= '0;
         drv_en  <= '0;
         lvl_pol <= '0;
         lvl_en  <= '0;
         edg_pol <= '0;
         edg_en  <= '0;
         top_en  <= 1'b0;
      end else if (reg_wr && hi_zero) begin
         case (ofs)
            OFS_DRV_VAL: drv_val <= reg_wdata[NPINS-1:0];
            OFS_DRV_EN:  drv_en  <= reg_wdata[NPINS-1:0];
            OFS_LVL_POL: lvl_pol <= reg_wdata[NPINS-1:0];
            OFS_LVL_EN:  lvl_en  <= reg_wdata[NPINS-1:0];
            OFS_EDG_POL: edg_pol <= reg_wdata[NPINS-1:0];
            OFS_EDG_EN:  edg_en  <= reg_wdata[NPINS-1:0];
            OFS_TOP_EN:  top_en  <= reg_wdata[0];
            default: ;
         endcase
      end
   end

   assign wr_flag = reg_wr && hi_zero && (ofs == OFS_EDG_FLAG);
   assign clr     = wr_flag ? reg_wdata[NPINS-1:0] : '0;

   for (genvar p = 0; p < NPINS; p++) begin : g_pin
      pin_cfg_t cfg;
      assign cfg.lvl_pol = lvl_pol[p];
      assign cfg.lvl_en  = lvl_en[p];
      assign cfg.edg_pol = edg_pol[p];
      assign cfg.edg_en  = edg_en[p];

      ioc_pin_slice u_slice (
         .clk  (clk),
         .rst_n(rst_n),
         .smp  (smp[p]),
         .cfg  (cfg),
         .clr  (clr[p]),
         .flag (flag[p]),
         .pend (pend[p])
      );
   end

   assign summary = |pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= summary & top_en;
   end

   assign pin_out = drv_val;
   assign pin_oe  = drv_en;

   always_comb begin
      reg_rdata = '0;
      if (hi_zero) begin
         case (ofs)
            OFS_TOP_STAT: reg_rdata[0]         = summary;
            OFS_TOP_EN:   reg_rdata[0]         = top_en;
            OFS_SAMPLE:   reg_rdata[NPINS-1:0] = smp;
            OFS_DRV_VAL:  reg_rdata[NPINS-1:0] = drv_val;
            OFS_DRV_EN:   reg_rdata[NPINS-1:0] = drv_en;
            OFS_LVL_POL:  reg_rdata[NPINS-1:0] = lvl_pol;
            OFS_LVL_EN:   reg_rdata[NPINS-1:0] = lvl_en;
            OFS_EDG_FLAG: reg_rdata[NPINS-1:0] = flag;
            OFS_EDG_EN:   reg_rdata[NPINS-1:0] = edg_en;
            OFS_EDG_POL:  reg_rdata[NPINS-1:0] = edg_pol;
            default: ;
         endcase
      end
   end

   // R9
   irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !top_en |=> !irq);
   // R9
   irq_follows_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (top_en && (pend != '0)) |=> irq);
   // R2
   drive_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && hi_zero && ofs == OFS_DRV_VAL) |=> (pin_out == $past(reg_wdata[NPINS-1:0])));
   // R2
   enable_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && hi_zero && ofs == OFS_DRV_EN) |=> (pin_oe == $past(reg_wdata[NPINS-1:0])));
   // R7
   masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_en == '0 && edg_en == '0) |-> (pend == '0));
endmodule

// File: tb/ioc_gpio_irq_test.sv
module ioc_gpio_irq_test;
   localparam int NP = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [7:0]    reg_addr = '0;
   logic          reg_wr = 1'b0;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic [NP-1:0] pin_in = '0;
   logic [NP-1:0] pin_out;
   logic [NP-1:0] pin_oe;
   logic          irq;

   int  n_chk = 0;
   int  n_err = 0;
   bit  done  = 1'b0;

   always #4 clk = ~clk;

   ioc_gpio_irq uut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
   );

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      reg_addr  = a;
      reg_wdata = d;
      reg_wr    = 1'b1;
      tick(1);
      reg_wr    = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      logic [7:0] ofs [10] = '{8'h00, 8'h04, 8'h40, 8'h44, 8'h48, 8'h50, 8'h54, 8'h58, 8'h5C, 8'h64};
      for (int i = 0; i < 10; i++) begin
         rd(ofs[i], v);
         check("R1 reg zero", v, 32'h0);
      end
      check("R1 pins", {pin_out, pin_oe}, 32'h0);
      check("R1 irq", {31'h0, irq}, 32'h0);
   endtask

   task automatic t_drive();
      logic [31:0] v;
      wr(8'h44, 32'hFFFF_A5C3);
      check("R2 pin_out", {16'h0, pin_out}, 32'h0000_A5C3);
      rd(8'h44, v);
      check("R2 readback", v, 32'h0000_A5C3);
      wr(8'h48, 32'h0000_0F0F);
      check("R2 pin_oe", {16'h0, pin_oe}, 32'h0000_0F0F);
      rd(8'h48, v);
      check("R2 oe readback", v, 32'h0000_0F0F);
   endtask

   task automatic t_sample();
      logic [31:0] v;
      pin_in[0] = 1'b1;  // pin 0 is driven (oe=1) yet still sampled
      pin_in[9] = 1'b1;
      tick(1);
      rd(8'h40, v);
      check("R3 one edge", v, 32'h0);
      tick(1);
      rd(8'h40, v);
      check("R3 two edges", v, 32'h0000_0201);
      pin_in = '0;
      tick(3);
      wr(8'h58, 32'hFFFF);
   endtask

   task automatic t_level();
      logic [31:0] v;
      wr(8'h54, 32'h0000_0008);
      rd(8'h00, v);
      check("R4 idle low", v, 32'h0);
      pin_in[3] = 1'b1;
      tick(1);
      rd(8'h00, v);
      check("R4 not yet", v, 32'h0);
      tick(1);
      rd(8'h00, v);
      check("R4 active high", v, 32'h1);
      wr(8'h50, 32'h0000_0008);
      rd(8'h00, v);
      check("R4 pol1 pin high", v, 32'h0);
      pin_in[3] = 1'b0;
      tick(2);
      rd(8'h00, v);
      check("R4 active low", v, 32'h1);
      wr(8'h54, 32'h0);
      rd(8'h00, v);
      check("R4 masked", v, 32'h0);
      wr(8'h50, 32'h0);
      tick(2);
      wr(8'h58, 32'hFFFF);
   endtask

   task automatic t_edge();
      logic [31:0] v;
      wr(8'h64, 32'h0000_0040);  // pin 6 falling, pin 5 rising
      pin_in[5] = 1'b1;
      pin_in[6] = 1'b1;
      tick(2);
      rd(8'h58, v);
      check("R5 not yet", v, 32'h0);
      tick(1);
      rd(8'h58, v);
      check("R5 rising sets", v, 32'h0000_0020);
      pin_in[5] = 1'b0;
      pin_in[6] = 1'b0;
      tick(4);
      rd(8'h58, v);
      check("R5 falling sets", v, 32'h0000_0060);
      rd(8'h00, v);
      check("R7 flag masked", v, 32'h0);
      wr(8'h5C, 32'h0000_0040);
      rd(8'h00, v);
      check("R7 flag enabled", v, 32'h1);
      wr(8'h58, 32'h0000_0020);
      rd(8'h58, v);
      check("R6 w1c one bit", v, 32'h0000_0040);
      wr(8'h58, 32'h0);
      rd(8'h58, v);
      check("R6 write zero keeps", v, 32'h0000_0040);
      wr(8'h58, 32'h0000_0040);
      rd(8'h00, v);
      check("R6 cleared status", v, 32'h0);
      wr(8'h5C, 32'h0);
      wr(8'h64, 32'h0);
   endtask

   task automatic t_status_irq();
      logic [31:0] v;
      wr(8'h54, 32'h0000_0002);
      pin_in[1] = 1'b1;
      tick(3);
      check("R9 irq gated", {31'h0, irq}, 32'h0);
      wr(8'h00, 32'h0);
      rd(8'h00, v);
      check("R8 write ignored", v, 32'h1);
      reg_addr = 8'h04;
      reg_wdata = 32'h1;
      reg_wr = 1'b1;
      @(posedge clk);
      @(negedge clk);
      reg_wr = 1'b0;
      check("R9 one edge after enable", {31'h0, irq}, 32'h0);
      tick(1);
      check("R9 irq high", {31'h0, irq}, 32'h1);
      pin_in[1] = 1'b0;
      tick(2);
      check("R9 irq still high", {31'h0, irq}, 32'h1);
      tick(1);
      check("R9 irq drops", {31'h0, irq}, 32'h0);
      wr(8'h54, 32'h0);
      wr(8'h04, 32'h0);
      wr(8'h58, 32'hFFFF);
   endtask

   task automatic t_collision();
      logic [31:0] v;
      pin_in[4] = 1'b1;
      tick(4);
      pin_in[4] = 1'b0;
      tick(4);
      rd(8'h58, v);
      check("R10 preset", v, 32'h0000_0010);
      pin_in[4] = 1'b1;
      tick(2);
      wr(8'h58, 32'h0000_0010);  // captured on the detection edge
      rd(8'h58, v);
      check("R10 edge wins", v, 32'h0000_0010);
      wr(8'h58, 32'h0000_0010);
      rd(8'h58, v);
      check("R10 later clear", v, 32'h0);
      pin_in[4] = 1'b0;
      tick(4);
   endtask

   task automatic t_unmapped();
      logic [31:0] v;
      wr(8'h20, 32'hFFFF_FFFF);
      rd(8'h20, v);
      check("R11 unmapped", v, 32'h0);
      rd(8'h60, v);
      check("R11 gap", v, 32'h0);
   endtask

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);
      t_reset();
      t_drive();
      t_sample();
      t_level();
      t_edge();
      t_status_irq();
      t_collision();
      t_unmapped();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end
endmodule